// File: doc/BRIEF.md
# SDRAM Command Spacing Guard

This block sits on the path from a command scheduler to the SDRAM command pins and refuses, cycle by cycle, any command that would come too soon after an earlier event. It enforces four programmable gaps: a read after a write, the shortest time the clock-enable pin may stay at either level, the wait after leaving power-down before any real command, and the wait after leaving self-refresh before a row activate.

The scheduler presents one request per cycle: a valid bit, a command code and the clock-enable level it wants. In the same cycle the guard either passes the command through with an issue strobe or raises a stall flag. A refused request stays refused until its gap has run out. The clock-enable output is registered. A level change that comes too early is held back until the current level has lasted its minimum width. Every gap field is a live input. A code of zero gives the same one-cycle spacing as a code of one, so a zero field never removes the spacing.

Top module: `sdg_timing_guard`

## Requirements
- R1: After a write (code 3) is issued, a read (code 2) is refused until N cycles have passed, where N is the larger of 1 and `cfg_wtr`. A read issues at the earliest in the Nth cycle after the write's cycle.
- R2: The command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5, SELF=6. `cmd_issue` is high when `req_valid` is high and the command is allowed. `stall` is high when `req_valid` is high and the command is refused. `cmd_out` equals `req_cmd` when issued and NOP otherwise. A gap holds back only the command types it names.
- R3: `cke_out` keeps each new level for at least N cycles, where N is the larger of 1 and `cfg_cke`. A `cke_req` that differs from the current level is held until that many cycles have passed, and is then taken at the next clock edge.
- R4: A low-to-high step of `cke_out` with no self-refresh pending is a power-down exit. After it, every command except NOP is refused in the first N-1 cycles with `cke_out` high, where N is the larger of 1 and `cfg_xp`.
- R5: An issued SELF command marks the next low-to-high step of `cke_out` as a self-refresh exit. After it, ACT alone is refused in the first N-1 cycles with `cke_out` high, where N is the larger of 1 and `cfg_xsr`. Other commands are not held, and the power-down-exit gap is not applied.
- R6: In every gap field a code of 0 behaves exactly like a code of 1: the next command, or the next level change, is allowed in the following cycle.
- R7: Reset drives `cke_out` high, clears every gap counter and the self-refresh mark, and leaves no command held.
- R8: A valid NOP is always issued. A cycle with `req_valid` low gives neither `cmd_issue` nor `stall`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 3 | Requested command code |
| cke_req | input | 1 | Clock-enable level the scheduler wants |
| cfg_wtr | input | 2 | Write-to-read gap code |
| cfg_cke | input | 3 | Minimum clock-enable level width code |
| cfg_xp | input | 3 | Power-down-exit to command gap code |
| cfg_xsr | input | 8 | Self-refresh-exit to activate gap code |
| cmd_issue | output | 1 | Command passed to the pins this cycle |
| cmd_out | output | 3 | Command driven to the pins (NOP when not issued) |
| stall | output | 1 | Request refused this cycle |
| cke_out | output | 1 | Registered clock-enable driven to the pins |

## Verification
`cmd_issue`, `stall` and `cmd_out` are combinational from the request and the counters, so their result is due in the same cycle the request is driven. `cke_out` changes one clock edge after a change request is accepted. A gap of N cycles started by an event in cycle t ends with the first allowed command in cycle t+N. The bench drives inputs just after a rising edge and samples at the falling edge of that same cycle. For the clock-enable, the expected level given in each vector is the one already registered at that sampling point. Each expected value was worked out by counting these edges from the event that loaded the gap.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
  localparam int CMD_W = 3;

  localparam logic [CMD_W-1:0] CMD_NOP  = 3'd0;
  localparam logic [CMD_W-1:0] CMD_ACT  = 3'd1;
  localparam logic [CMD_W-1:0] CMD_RD   = 3'd2;
  localparam logic [CMD_W-1:0] CMD_WR   = 3'd3;
  localparam logic [CMD_W-1:0] CMD_PRE  = 3'd4;
  localparam logic [CMD_W-1:0] CMD_REF  = 3'd5;
  localparam logic [CMD_W-1:0] CMD_SELF = 3'd6;

  // A gap of N cycles loads N-1; code 0 counts as code 1, so both load 0.
  function automatic logic [15:0] spacing_load(input logic [15:0] code);
    return (code == 16'd0) ? 16'd0 : code - 16'd1;
  endfunction
endpackage

// File: rtl/sdg_gap_counter.sv
module sdg_gap_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/sdg_cke_ctrl.sv
module sdg_cke_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_req,
  input  logic cke_busy,
  input  logic self_issued,
  output logic cke_out,
  output logic cke_flip,
  output logic pd_exit,
  output logic sr_exit
);
  logic cke_q;
  logic sr_pending_q;
  logic rise;

  assign cke_flip = (cke_req != cke_q) && !cke_busy;
  assign rise     = cke_flip && cke_req;
  assign pd_exit  = rise && !sr_pending_q;
  assign sr_exit  = rise && sr_pending_q;
  assign cke_out  = cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q        <= 1'b1;
      sr_pending_q <= 1'b0;
    end else begin
      if (cke_flip) cke_q <= cke_req;
      if (sr_exit)          sr_pending_q <= 1'b0;
      else if (self_issued) sr_pending_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sdg_timing_guard.sv
module sdg_timing_guard
  import sdg_pkg::*;
#(
  parameter int WTR_W = 2,
  parameter int CKE_W = 3,
  parameter int XP_W  = 3,
  parameter int XSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic             cke_req,
  input  logic [WTR_W-1:0] cfg_wtr,
  input  logic [CKE_W-1:0] cfg_cke,
  input  logic [XP_W-1:0]  cfg_xp,
  input  logic [XSR_W-1:0] cfg_xsr,
  output logic             cmd_issue,
  output logic [CMD_W-1:0] cmd_out,
  output logic             stall,
  output logic             cke_out
);
  // Named internal events, brought out for the checker.
  logic wtr_busy, cke_busy, xp_busy, xsr_busy;
  logic cke_flip, pd_exit, sr_exit;
  logic wr_issued, self_issued, allowed;

  logic [WTR_W-1:0] wtr_load;
  logic [CKE_W-1:0] cke_load;
  logic [XP_W-1:0]  xp_load;
  logic [XSR_W-1:0] xsr_load;

  assign wtr_load = WTR_W'(spacing_load(16'(cfg_wtr)));
  assign cke_load = CKE_W'(spacing_load(16'(cfg_cke)));
  assign xp_load  = XP_W'(spacing_load(16'(cfg_xp)));
  assign xsr_load = XSR_W'(spacing_load(16'(cfg_xsr)));

  always_comb begin
    allowed = 1'b1;
    if (req_cmd != CMD_NOP) begin
      if (xp_busy)                        allowed = 1'b0;
      if (req_cmd == CMD_RD  && wtr_busy) allowed = 1'b0;
      if (req_cmd == CMD_ACT && xsr_busy) allowed = 1'b0;
    end
  end

  assign cmd_issue   = req_valid && allowed;
  assign stall       = req_valid && !allowed;
  assign cmd_out     = cmd_issue ? req_cmd : CMD_NOP;
  assign wr_issued   = cmd_issue && (req_cmd == CMD_WR);
  assign self_issued = cmd_issue && (req_cmd == CMD_SELF);

  sdg_gap_counter #(.W(WTR_W)) u_wtr_cnt (
    .clk(clk), .rst_n(rst_n), .load(wr_issued), .load_val(wtr_load), .busy(wtr_busy));

  sdg_gap_counter #(.W(CKE_W)) u_cke_cnt (
    .clk(clk), .rst_n(rst_n), .load(cke_flip), .load_val(cke_load), .busy(cke_busy));

  sdg_gap_counter #(.W(XP_W)) u_xp_cnt (
    .clk(clk), .rst_n(rst_n), .load(pd_exit), .load_val(xp_load), .busy(xp_busy));

  sdg_gap_counter #(.W(XSR_W)) u_xsr_cnt (
    .clk(clk), .rst_n(rst_n), .load(sr_exit), .load_val(xsr_load), .busy(xsr_busy));

  sdg_cke_ctrl u_cke_ctrl (
    .clk(clk), .rst_n(rst_n), .cke_req(cke_req), .cke_busy(cke_busy),
    .self_issued(self_issued), .cke_out(cke_out), .cke_flip(cke_flip),
    .pd_exit(pd_exit), .sr_exit(sr_exit));
endmodule

// File: rtl/sdg_guard_chk.sv
module sdg_guard_chk
  import sdg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [CMD_W-1:0] req_cmd,
  input logic [1:0]       cfg_wtr,
  input logic [2:0]       cfg_cke,
  input logic [2:0]       cfg_xp,
  input logic [7:0]       cfg_xsr,
  input logic             cmd_issue,
  input logic             stall,
  input logic             cke_out,
  input logic             pd_exit,
  input logic             sr_exit
);
  p_rd_after_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && req_cmd == CMD_WR && cfg_wtr > 2'd1) |=> !(cmd_issue && req_cmd == CMD_RD));

  p_issue_stall_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_issue && stall));

  p_cke_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cke_out) && cfg_cke > 3'd1) |=> $stable(cke_out));

  p_pd_exit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_exit && cfg_xp > 3'd1) |=> !(cmd_issue && req_cmd != CMD_NOP));

  p_sr_exit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_exit && cfg_xsr > 8'd1) |=> !(cmd_issue && req_cmd == CMD_ACT));

  p_reset_cke_r7: assert property (@(posedge clk)
    !rst_n |=> cke_out);

  p_nop_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == CMD_NOP) |-> (cmd_issue && !stall));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!cmd_issue && !stall));
endmodule

bind sdg_timing_guard sdg_guard_chk u_guard_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .cfg_wtr(cfg_wtr), .cfg_cke(cfg_cke), .cfg_xp(cfg_xp), .cfg_xsr(cfg_xsr),
  .cmd_issue(cmd_issue), .stall(stall), .cke_out(cke_out),
  .pd_exit(pd_exit), .sr_exit(sr_exit));

// File: tb/test_sdg_timing_guard.sv
module test_sdg_timing_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic       cke_req = 1'b1;
  logic [1:0] cfg_wtr = 2'd0;
  logic [2:0] cfg_cke = 3'd0;
  logic [2:0] cfg_xp  = 3'd0;
  logic [7:0] cfg_xsr = 8'd0;
  logic       cmd_issue, stall, cke_out;
  logic [2:0] cmd_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sdg_timing_guard i_sdg_timing_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .cke_req(cke_req), .cfg_wtr(cfg_wtr), .cfg_cke(cfg_cke), .cfg_xp(cfg_xp),
    .cfg_xsr(cfg_xsr), .cmd_issue(cmd_issue), .cmd_out(cmd_out),
    .stall(stall), .cke_out(cke_out));

  // Vector: {valid, cmd[2:0], cke_req, expected issue, expected cke_out}
  // Gap codes during the table: wtr=3, cke=3, xp=2, xsr=4.
  localparam logic [6:0] VEC [24] = '{
    7'b1_011_1_1_1,  //  0 WR issues, write-to-read gap starts (R1)
    7'b1_010_1_0_1,  //  1 RD held (R1)
    7'b1_010_1_0_1,  //  2 RD held (R1)
    7'b1_010_1_1_1,  //  3 RD issues three cycles after WR (R1)
    7'b1_011_1_1_1,  //  4 WR issues
    7'b1_001_1_1_1,  //  5 ACT not held by write gap (R2)
    7'b1_010_1_0_1,  //  6 RD held (R1)
    7'b1_010_1_1_1,  //  7 RD issues (R1)
    7'b1_000_0_1_1,  //  8 request CKE low, taken at this edge (R3)
    7'b1_000_1_1_0,  //  9 CKE low, rise held (R3)
    7'b1_000_1_1_0,  // 10 rise held (R3)
    7'b1_000_1_1_0,  // 11 rise taken at this edge: power-down exit (R3)
    7'b1_100_1_0_1,  // 12 PRE held after power-down exit (R4)
    7'b1_100_1_1_1,  // 13 PRE issues (R4)
    7'b1_110_1_1_1,  // 14 SELF issues, marks self-refresh (R5)
    7'b1_000_0_1_1,  // 15 request CKE low, taken (R3)
    7'b1_000_1_1_0,  // 16 rise held (R3)
    7'b1_000_1_1_0,  // 17 rise held (R3)
    7'b1_000_1_1_0,  // 18 rise taken: self-refresh exit (R5)
    7'b1_001_1_0_1,  // 19 ACT held (R5)
    7'b1_010_1_1_1,  // 20 RD not held after self-refresh exit (R5)
    7'b1_001_1_0_1,  // 21 ACT held (R5)
    7'b1_001_1_1_1,  // 22 ACT issues (R5)
    7'b0_001_1_0_1   // 23 no request: no issue, no stall (R8)
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] c, input logic k);
    @(posedge clk);
    #1;
    req_valid = v;
    req_cmd   = c;
    cke_req   = k;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    req_valid = 1'b0;
    cke_req = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state (R7)
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 cke_out after reset", int'(cke_out), 1);
    chk("R7 no stall after reset", int'(stall), 0);
    chk("R8 idle no issue", int'(cmd_issue), 0);

    // Table walk
    cfg_wtr = 2'd3; cfg_cke = 3'd3; cfg_xp = 3'd2; cfg_xsr = 8'd4;
    for (int i = 0; i < 24; i++) begin
      logic [6:0] v;
      v = VEC[i];
      step(v[6], v[5:3], v[2]);
      chk($sformatf("R2 issue vec %0d", i), int'(cmd_issue), int'(v[1]));
      chk($sformatf("R2 stall vec %0d", i), int'(stall), int'(v[6] && !v[1]));
      chk($sformatf("R2 cmd_out vec %0d", i), int'(cmd_out), v[1] ? int'(v[5:3]) : 0);
      chk($sformatf("R3 cke_out vec %0d", i), int'(cke_out), int'(v[0]));
    end

    // Zero codes act as one cycle (R6)
    cfg_wtr = 2'd0; cfg_cke = 3'd0; cfg_xp = 3'd0; cfg_xsr = 8'd0;
    do_reset();
    step(1'b1, 3'd3, 1'b1);
    chk("R6 WR issues", int'(cmd_issue), 1);
    step(1'b1, 3'd2, 1'b1);
    chk("R6 RD right after WR with code 0", int'(cmd_issue), 1);
    cfg_wtr = 2'd1;
    step(1'b1, 3'd3, 1'b1);
    step(1'b1, 3'd2, 1'b1);
    chk("R6 RD right after WR with code 1", int'(cmd_issue), 1);
    step(1'b1, 3'd0, 1'b0);
    step(1'b1, 3'd0, 1'b1);
    chk("R6 CKE low after one-cycle request", int'(cke_out), 0);
    step(1'b1, 3'd4, 1'b1);
    chk("R6 CKE high after one-cycle low width", int'(cke_out), 1);
    chk("R4 PRE right after power-down exit with code 0", int'(cmd_issue), 1);

    // Reset clears gaps and forces CKE high (R7)
    cfg_wtr = 2'd3;
    step(1'b1, 3'd3, 1'b0);
    @(negedge clk);
    chk("R7 CKE low before reset", int'(cke_out), 0);
    do_reset();
    @(negedge clk);
    chk("R7 CKE high after reset", int'(cke_out), 1);
    step(1'b1, 3'd2, 1'b1);
    chk("R7 RD issues, write gap cleared by reset", int'(cmd_issue), 1);
    step(1'b1, 3'd0, 1'b1);
    chk("R8 NOP issues", int'(cmd_issue), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule